// File: doc/BRIEF.md
# Serial Peripheral Master With Register Port

This block is a byte-wide serial peripheral master that a processor controls through four small registers on a synchronous register port. Software picks the serial clock rate, the clock polarity and the clock phase, drives the slave-select lines, and starts a transfer by writing a byte. The block then shifts that byte out on `mosi`, most significant bit first, and shifts a byte in from `miso` at the same time. Software polls a busy flag until it clears, then reads the received byte back.

The shift engine is a four-state machine. `ST_IDLE` holds `sck` at the polarity level and waits for a data write (transition *start*). `ST_SETUP` waits one half-period so that the first bit is stable on `mosi` before any clock edge (transition *lead done*). `ST_SHIFT` toggles `sck` once per half-period for sixteen edges and samples or launches a bit on each edge (transition *last edge*). `ST_HOLD` waits one more half-period, then copies the received byte into the receive register and returns to `ST_IDLE` (transition *finish*). From any state, a falling edge on the synchronised external select input forces `ST_IDLE` (transition *abort*).

The external active-low select input signals that another master has claimed the bus. Its falling edge aborts the transfer, releases every slave select and raises a sticky fault flag.

Top module: `spi_ctrl`

## Requirements
- R1: A data write (`reg_sel`=2) while not busy sends the 8-bit byte on `mosi`, most significant bit first. Each bit is stable at the sampling edge of `sck`. The sampling edge is rising when polarity equals phase and falling otherwise.
- R2: During each transfer the block samples `miso` on the sampling edge, most significant bit first. After the last bit the byte is readable at `reg_sel`=2. An aborted transfer leaves this register unchanged.
- R3: Control register (`reg_sel`=0): bits [1:0] select the divider, bit 2 is polarity and bit 3 is phase. The register reads back as written.
- R4: With phase 0, bit 7 of the byte is on `mosi` before the first `sck` edge. With phase 1, the first `sck` edge launches the first bit, and sampling happens on the trailing edges.
- R5: Status bit 0 (`reg_sel`=1) reads 1 from the cycle after a data write until the transfer ends, and reads 0 at all other times.
- R6: `sck` equals the polarity bit whenever no transfer is active, including after reset and after an abort.
- R7: The `sck` period is 4, 8, 16 or 32 system clocks for divider values 0, 1, 2 and 3.
- R8: Writes to the control register while busy are ignored.
- R9: `sel_n` drives the low bits of the select register (`reg_sel`=3). After reset `sel_n` is all ones.
- R10: A falling edge on `ext_sel_n` aborts any transfer. Within four clocks, busy clears, `sel_n` returns to all ones and `sck` returns to polarity. The fault flag, status bit 1, is set.
- R11: The fault flag stays set until a status write with bit 1 high. A status write with bit 1 low leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 select |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | NSEL | Active-low slave selects |
| ext_sel_n | input | 1 | Active-low external select, asynchronous |

## Verification
A bad edge counter or a wrong state shows up on the ports within one byte. The transmitted or received byte is shifted by one bit, or the busy flag is still set after eighteen half-periods. A polarity or phase decode error makes a slave model that follows the stated edge rules capture a wrong byte. An error in the half-period counter changes the measured spacing between `sck` rising edges, and the bench reads that spacing after every transfer. A fault in abort handling leaves `sel_n` low or `sck` off its idle level, and the bench sees this four clocks after the external select falls.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } xfer_state_t;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2,
        RA_SEL  = 2'd3
    } reg_addr_t;

    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_FAULT_BIT = 1;

endpackage

// File: rtl/spi_tick_gen.sv
// Half-period tick generator: while run is high it pulses tick once every
// (2 << div) system clocks; while run is low it stays reloaded.
module spi_tick_gen #(
    parameter int DIVW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    localparam int MAX_HALF = 2 << ((1 << DIVW) - 1);
    localparam int CW       = $clog2(MAX_HALF);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    assign reload = CW'((2 << div) - 1);
    assign tick   = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == '0)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/spi_ext_sync.sv
// Synchroniser for the asynchronous external select plus falling-edge pulse.
module spi_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], async_n};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign fall = prev & ~lvl;
endmodule

// File: rtl/spi_shift_fsm.sv
// Byte shift engine covering all four polarity/phase modes.
module spi_shift_fsm
    import spi_ctrl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         miso,
    input  logic [W-1:0] tx_byte,
    output logic         busy,
    output logic         sck,
    output logic         mosi,
    output logic         rx_valid,
    output logic [W-1:0] rx_byte
);
    localparam int EDGES = 2 * W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    xfer_state_t   state_q, state_d;
    logic [EW-1:0] edge_cnt;
    logic [W-1:0]  shreg;
    logic [W-1:0]  rxsh;
    logic          lead_edge, sample_edge, launch_edge;

    // leading edge = even edge index; sampling edge depends on phase
    assign lead_edge   = ~edge_cnt[0];
    assign sample_edge = lead_edge ^ cpha;
    assign launch_edge = ~sample_edge & ~(cpha & (edge_cnt == '0));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_d = ST_SETUP;
                ST_SETUP: if (tick)  state_d = ST_SHIFT;
                ST_SHIFT: if (tick && edge_cnt == LAST_EDGE) state_d = ST_HOLD;
                ST_HOLD:  if (tick)  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck      <= 1'b0;
            shreg    <= '0;
            rxsh     <= '0;
            edge_cnt <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (abort) begin
                sck      <= cpol;
                edge_cnt <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        sck <= cpol;
                        if (start) begin
                            shreg    <= tx_byte;
                            edge_cnt <= '0;
                        end
                    end
                    ST_SHIFT: begin
                        if (tick) begin
                            sck      <= ~sck;
                            edge_cnt <= edge_cnt + 1'b1;
                            if (sample_edge)
                                rxsh <= {rxsh[W-2:0], miso};
                            if (launch_edge)
                                shreg <= {shreg[W-2:0], 1'b0};
                        end
                    end
                    ST_HOLD: begin
                        if (tick) begin
                            rx_valid <= 1'b1;
                            rx_byte  <= rxsh;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign mosi = shreg[W-1];
endmodule

// File: rtl/spi_ctrl.sv
// Serial peripheral master with a four-register synchronous port.
module spi_ctrl
    import spi_ctrl_pkg::*;
#(
    parameter int NSEL = 4,
    parameter int DW   = 8,
    parameter int DIVW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      reg_sel,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] sel_n,
    input  logic            ext_sel_n
);
    localparam int CPOL_BIT = DIVW;
    localparam int CPHA_BIT = DIVW + 1;

    logic [DIVW-1:0] cfg_div;
    logic            cfg_cpol, cfg_cpha;
    logic [NSEL-1:0] sel_q;
    logic            fault_q;
    logic [DW-1:0]   rx_q;

    logic            busy, tick, rx_valid;
    logic [DW-1:0]   rx_byte;
    logic            ext_lvl, ext_fall;
    logic            wr_ctrl, wr_stat, wr_data, wr_sel, start;
    logic            wdata_unused;

    assign wdata_unused = ^reg_wdata;

    assign wr_ctrl = reg_wr && (reg_sel == RA_CTRL);
    assign wr_stat = reg_wr && (reg_sel == RA_STAT);
    assign wr_data = reg_wr && (reg_sel == RA_DATA);
    assign wr_sel  = reg_wr && (reg_sel == RA_SEL);
    assign start   = wr_data && !busy && !ext_fall;

    spi_ext_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (ext_sel_n),
        .lvl     (ext_lvl),
        .fall    (ext_fall)
    );

    spi_tick_gen #(.DIVW(DIVW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_shift_fsm #(.W(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (ext_fall),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .tick     (tick),
        .miso     (miso),
        .tx_byte  (reg_wdata),
        .busy     (busy),
        .sck      (sck),
        .mosi     (mosi),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div  <= '0;
            cfg_cpol <= 1'b0;
            cfg_cpha <= 1'b0;
            sel_q    <= '1;
            fault_q  <= 1'b0;
            rx_q     <= '0;
        end else begin
            if (wr_ctrl && !busy) begin
                cfg_div  <= reg_wdata[DIVW-1:0];
                cfg_cpol <= reg_wdata[CPOL_BIT];
                cfg_cpha <= reg_wdata[CPHA_BIT];
            end
            if (ext_fall)
                sel_q <= '1;
            else if (wr_sel)
                sel_q <= reg_wdata[NSEL-1:0];
            if (ext_fall)
                fault_q <= 1'b1;
            else if (wr_stat && reg_wdata[STAT_FAULT_BIT])
                fault_q <= 1'b0;
            if (rx_valid)
                rx_q <= rx_byte;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_t'(reg_sel))
            RA_CTRL: reg_rdata[CPHA_BIT:0] = {cfg_cpha, cfg_cpol, cfg_div};
            RA_STAT: begin
                reg_rdata[STAT_BUSY_BIT]  = busy;
                reg_rdata[STAT_FAULT_BIT] = fault_q;
            end
            RA_DATA: reg_rdata = rx_q;
            RA_SEL:  reg_rdata[NSEL-1:0] = sel_q;
            default: reg_rdata = '0;
        endcase
    end

    assign sel_n = sel_q;
endmodule

// File: rtl/spi_ctrl_chk.sv
// Property checker attached to spi_ctrl.
module spi_ctrl_chk #(
    parameter int NSEL = 4,
    parameter int DIVW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_sel,
    input logic            clr_bit,
    input logic            sck,
    input logic [NSEL-1:0] sel_n,
    input logic            busy,
    input logic [DIVW-1:0] cfg_div,
    input logic            cfg_cpol,
    input logic            cfg_cpha,
    input logic            fault_q,
    input logic            ext_lvl,
    input logic            ext_fall
);
    // R6: idle clock level follows polarity
    p_idle_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $stable(cfg_cpol)) |-> (sck == cfg_cpol));

    // R8: configuration frozen during a transfer
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({cfg_div, cfg_cpol, cfg_cpha}));

    // R10: external select falling edge aborts and flags
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_lvl) |=> (!busy && (&sel_n) && fault_q));

    // R11: fault flag is sticky
    p_fault_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(reg_wr && reg_sel == 2'd1 && clr_bit)) |=> fault_q);

    // R5: data write while idle raises busy
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2 && !busy && !ext_fall) |=> busy);
endmodule

bind spi_ctrl spi_ctrl_chk #(.NSEL(NSEL), .DIVW(DIVW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .clr_bit  (reg_wdata[1]),
    .sck      (sck),
    .sel_n    (sel_n),
    .busy     (busy),
    .cfg_div  (cfg_div),
    .cfg_cpol (cfg_cpol),
    .cfg_cpha (cfg_cpha),
    .fault_q  (fault_q),
    .ext_lvl  (ext_lvl),
    .ext_fall (ext_fall)
);

// File: tb/spi_ctrl_test.sv
module spi_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck, mosi, miso;
    logic [3:0] sel_n;
    logic       ext_sel_n = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    // slave model state
    int         sl_edges = 0;
    int         sl_bits = 0;
    logic [7:0] sl_cap = 8'h00;
    logic [7:0] sl_pat = 8'h00;
    logic       cur_cpha = 1'b0;
    logic       sl_arm = 1'b0;

    int cyc = 0;
    int t_prev = 0;
    int t_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .sel_n     (sel_n),
        .ext_sel_n (ext_sel_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = a;
        #1;
        d = reg_rdata;
    endtask

    always @(posedge clk) cyc++;
    always @(posedge sck) begin
        t_prev = t_last;
        t_last = cyc;
    end

    // monitor: slave samples mosi on the sampling edge and scores each byte
    always @(sck) begin
        if (sl_arm && sel_n != 4'hF) begin
            if ((sl_edges & 1) == int'(cur_cpha)) begin
                sl_cap = {sl_cap[6:0], mosi};
                sl_bits++;
                if (sl_bits == 8) begin
                    if (exp_q.size() == 0)
                        check("R1 unexpected byte", {24'd0, sl_cap}, 32'hFFFF_FFFF);
                    else
                        check("R1 mosi byte", {24'd0, sl_cap}, {24'd0, exp_q.pop_front()});
                end
            end
            sl_edges++;
        end
    end

    // slave launches its bits on the non-sampling edge
    always @* begin
        int idx;
        if (!cur_cpha) idx = sl_edges / 2;
        else idx = (sl_edges == 0) ? 0 : (sl_edges - 1) / 2;
        miso = (idx < 8) ? sl_pat[7 - idx] : 1'b0;
    end

    task automatic xfer(input logic cpol, input logic cpha, input logic [1:0] dv,
                        input logic [7:0] tx, input logic [7:0] pat, input logic poke);
        logic [7:0] st;
        logic [7:0] cfg;
        int n;
        cfg = {4'b0, cpha, cpol, dv};
        wr(2'd0, cfg);
        @(negedge clk);
        cur_cpha = cpha; sl_pat = pat; sl_edges = 0; sl_bits = 0; sl_cap = 8'h00; sl_arm = 1'b1;
        wr(2'd3, 8'hFE);
        check("R9 sel_n follows register", {28'd0, sel_n}, 32'hE);
        exp_q.push_back(tx);
        wr(2'd2, tx);
        check("R4 first bit before first edge", {31'd0, mosi}, {31'd0, tx[7]});
        check("R4 no edge yet", {31'd0, sck}, {31'd0, cpol});
        rd(2'd1, st);
        check("R5 busy during transfer", {31'd0, st[0]}, 32'd1);
        if (poke) wr(2'd0, ~cfg);
        n = 0;
        do begin
            rd(2'd1, st);
            n++;
        end while (st[0] && n < 5000);
        check("R5 busy cleared", {31'd0, st[0]}, 32'd0);
        check("R7 sck period", t_last - t_prev, 4 << dv);
        check("R6 sck idle level", {31'd0, sck}, {31'd0, cpol});
        rd(2'd2, st);
        check("R2 received byte", {24'd0, st}, {24'd0, pat});
        rd(2'd0, st);
        check(poke ? "R8 control ignored while busy" : "R3 control readback", {24'd0, st}, {24'd0, cfg});
        wr(2'd3, 8'hFF);
        sl_arm = 1'b0;
    endtask

    task automatic abort_case(input logic [7:0] last_pat);
        logic [7:0] st;
        wr(2'd0, 8'h03);
        @(negedge clk);
        cur_cpha = 1'b0; sl_pat = 8'h00; sl_edges = 0; sl_bits = 0; sl_arm = 1'b1;
        wr(2'd3, 8'hFD);
        wr(2'd2, 8'h5A);
        repeat (40) @(negedge clk);
        ext_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 selects released", {28'd0, sel_n}, 32'hF);
        check("R10 sck back to idle", {31'd0, sck}, 32'd0);
        rd(2'd1, st);
        check("R10 fault set and busy clear", {30'd0, st[1:0]}, 32'h2);
        rd(2'd2, st);
        check("R2 abort keeps receive register", {24'd0, st}, {24'd0, last_pat});
        wr(2'd1, 8'h00);
        rd(2'd1, st);
        check("R11 fault sticky", {31'd0, st[1]}, 32'd1);
        ext_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd1, 8'h02);
        rd(2'd1, st);
        check("R11 fault cleared", {30'd0, st[1:0]}, 32'd0);
        sl_arm = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R5 watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] st;
        repeat (3) @(negedge clk);
        check("R9 reset selects", {28'd0, sel_n}, 32'hF);
        check("R6 reset sck", {31'd0, sck}, 32'd0);
        rst_n = 1'b1;
        rd(2'd1, st);
        check("R5 reset status", {24'd0, st}, 32'd0);

        xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 1'b0);
        xfer(1'b0, 1'b1, 2'd1, 8'h81, 8'hE7, 1'b0);
        xfer(1'b1, 1'b0, 2'd2, 8'h7E, 8'h01, 1'b0);
        xfer(1'b1, 1'b1, 2'd0, 8'hC3, 8'h96, 1'b0);
        xfer(1'b1, 1'b1, 2'd3, 8'h0F, 8'hF0, 1'b1);
        xfer(1'b0, 1'b0, 2'd1, 8'hFF, 8'h00, 1'b0);
        abort_case(8'h00);
        xfer(1'b0, 1'b1, 2'd2, 8'h12, 8'hB4, 1'b0);

        check("R1 all bytes seen", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule